// File: doc/BRIEF.md
# Thermometer-Coded Manhattan Distance Grid

This block holds a rectangular grid of cells, one per pixel, and computes for every object pixel its 4-connected (city-block) distance to the nearest background pixel. Each distance is stored as a thermometer code. A distance of d is a run of d ones starting at the least significant bit. With this encoding, the smallest of several distances is the bitwise AND of their codes, and adding one step is a left shift with a 1 entering at bit 0. The code saturates at the all-ones word. With the default 8-bit code, distances of eight or more all read as eight.

A client drives a binary map on `obj_map` (1 marks an object pixel) and pulses `start` for one cycle. The grid captures the map and clears every code to zero. On each following cycle, every object cell replaces its code with the OR of its current code and the stepped minimum of its four neighbours. Codes therefore only gain ones. Positions outside the grid count as saturated neighbours. When a cycle passes in which no code changes, `done` rises. It stays high, with the codes frozen, until the next `start`. Objects wider than the code range need further passes by the client. Those passes are outside this block.

Top module: `dt_grid`

## Requirements
- R1: Cell (r,c) has index r*COLS+c. Its object bit is `obj_map[index]`, where 1 means object and 0 means background. Its code is `dist_codes[index*CODE_W +: CODE_W]`. A distance d is encoded as d ones in the low bits, so 0 is 00000000 and 3 is 00000111.
- R2: Background cells read 00000000 at all times after a start.
- R3: Once `done` is high, each object cell reads the code for min(8, |dr|+|dc| to the nearest background cell). Positions outside the grid never act as background.
- R4: When the map has no background cell, every cell saturates at 11111111.
- R5: After k update cycles following the start edge, each object cell reads the code for min(k, final distance). No code ever loses a 1 bit between consecutive cycles unless `start` is high.
- R6: `done` is low while the grid is updating. It rises exactly D+1 clock edges after the edge that takes `start`, where D is the largest final distance in the map. It then holds, with the codes unchanged, until the next `start`.
- R7: The edge that takes `start` clears all codes to zero and drops `done`. This also happens when `start` arrives in the middle of a computation, and the new map is then computed from scratch.
- R8: After reset, all codes read zero and `done` is low.
- R9: Every cell's code is a valid thermometer word on every cycle.
- R10: Changes on `obj_map` after the start edge have no effect on the result. The map is captured only when `start` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture `obj_map` and begin a new computation |
| obj_map | input | ROWS*COLS | Object map, 1 = object pixel |
| dist_codes | output | ROWS*COLS*CODE_W | Thermometer distance code of every cell |
| done | output | 1 | High once the codes have stopped changing |

## Verification
A cell that misreads a neighbour, or an edge tied to the wrong value, shows up as a wrong code one cycle after the first wrong step. The bench checks the whole grid on every cycle against the exact min(k, d) trajectory, so such a fault appears within a cycle or two of the start edge. A faulty change detector moves the rising edge of `done` away from D+1. A mask that is not captured at start only shows after the map is altered during a run, and that case is exercised explicitly. The map set covers all-background and all-object grids, every single-background placement, and a spread of random maps.

// File: rtl/dt_pkg.sv
package dt_pkg;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } dt_phase_e;

endpackage

// File: rtl/dt_cell.sv
// One grid cell: stepped minimum of four neighbours, merged into its own code.
module dt_cell #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] own_q,
    input  logic [CODE_W-1:0] nb_up,
    input  logic [CODE_W-1:0] nb_down,
    input  logic [CODE_W-1:0] nb_left,
    input  logic [CODE_W-1:0] nb_right,
    input  logic              is_obj,
    output logic [CODE_W-1:0] own_d,
    output logic              grows
);

    logic [CODE_W-1:0] meet;
    logic [CODE_W-1:0] stepped;

    always_comb begin
        // thermometer minimum is a plain AND
        meet    = nb_up & nb_down & nb_left & nb_right;
        // one step further: shift up, fill a one; top bit falls off at saturation
        stepped = {meet[CODE_W-2:0], 1'b1};
        if (is_obj) begin
            own_d = own_q | stepped;
        end else begin
            own_d = '0;
        end
        grows = (own_d != own_q);
    end

endmodule

// File: rtl/dt_ctrl.sv
// Sequencer: load on start, step while any cell grows, flag completion.
module dt_ctrl
    import dt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic any_grow,
    output logic load,
    output logic step_en,
    output logic running,
    output logic fin
);

    typedef struct packed {
        dt_phase_e phase;
        logic      fin;
    } ctrl_t;

    ctrl_t ctl_q;
    ctrl_t ctl_d;

    always_comb begin
        ctl_d   = ctl_q;
        load    = start;
        step_en = (ctl_q.phase == PH_RUN) && !start;
        if (start) begin
            ctl_d.phase = PH_RUN;
            ctl_d.fin   = 1'b0;
        end else if (ctl_q.phase == PH_RUN && !any_grow) begin
            ctl_d.phase = PH_IDLE;
            ctl_d.fin   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.phase <= PH_IDLE;
            ctl_q.fin   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign running = (ctl_q.phase == PH_RUN);
    assign fin     = ctl_q.fin;

endmodule

// File: rtl/dt_grid.sv
// Grid of thermometer distance cells with edge cells seeing saturated neighbours.
module dt_grid #(
    parameter int ROWS   = 8,
    parameter int COLS   = 8,
    parameter int CODE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [ROWS*COLS-1:0]          obj_map,
    output logic [ROWS*COLS*CODE_W-1:0]   dist_codes,
    output logic                          done
);

    localparam int NCELL = ROWS * COLS;
    localparam int VEC_W = NCELL * CODE_W;

    typedef struct packed {
        logic [NCELL-1:0] mask;
        logic [VEC_W-1:0] codes;
    } grid_t;

    grid_t grid_q;
    grid_t grid_d;

    logic              load;
    logic              step_en;
    logic              running;
    logic              any_grow;
    logic [NCELL-1:0]  grow_vec;
    logic [CODE_W-1:0] cur_code  [NCELL];
    logic [CODE_W-1:0] next_code [NCELL];

    genvar gr, gc;
    generate
        for (gr = 0; gr < ROWS; gr++) begin : g_row
            for (gc = 0; gc < COLS; gc++) begin : g_col
                localparam int IDX = gr * COLS + gc;
                logic [CODE_W-1:0] n_up, n_dn, n_lf, n_rt;

                assign cur_code[IDX] = grid_q.codes[IDX*CODE_W +: CODE_W];

                if (gr == 0) begin : g_top
                    assign n_up = '1;
                end else begin : g_top_in
                    assign n_up = grid_q.codes[(IDX-COLS)*CODE_W +: CODE_W];
                end
                if (gr == ROWS-1) begin : g_bot
                    assign n_dn = '1;
                end else begin : g_bot_in
                    assign n_dn = grid_q.codes[(IDX+COLS)*CODE_W +: CODE_W];
                end
                if (gc == 0) begin : g_lft
                    assign n_lf = '1;
                end else begin : g_lft_in
                    assign n_lf = grid_q.codes[(IDX-1)*CODE_W +: CODE_W];
                end
                if (gc == COLS-1) begin : g_rgt
                    assign n_rt = '1;
                end else begin : g_rgt_in
                    assign n_rt = grid_q.codes[(IDX+1)*CODE_W +: CODE_W];
                end

                dt_cell #(.CODE_W(CODE_W)) u_cell (
                    .own_q    (cur_code[IDX]),
                    .nb_up    (n_up),
                    .nb_down  (n_dn),
                    .nb_left  (n_lf),
                    .nb_right (n_rt),
                    .is_obj   (grid_q.mask[IDX]),
                    .own_d    (next_code[IDX]),
                    .grows    (grow_vec[IDX])
                );
            end
        end
    endgenerate

    assign any_grow = |grow_vec;

    dt_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .any_grow (any_grow),
        .load     (load),
        .step_en  (step_en),
        .running  (running),
        .fin      (done)
    );

    always_comb begin
        grid_d = grid_q;
        if (load) begin
            grid_d.mask  = obj_map;
            grid_d.codes = '0;
        end else if (step_en) begin
            for (int i = 0; i < NCELL; i++) begin
                grid_d.codes[i*CODE_W +: CODE_W] = next_code[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grid_q.mask  <= '0;
            grid_q.codes <= '0;
        end else begin
            grid_q <= grid_d;
        end
    end

    assign dist_codes = grid_q.codes;

endmodule

// File: rtl/dt_grid_chk.sv
module dt_grid_chk #(
    parameter int ROWS   = 8,
    parameter int COLS   = 8,
    parameter int CODE_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start,
    input logic                        done,
    input logic                        running,
    input logic [ROWS*COLS-1:0]        mask,
    input logic [ROWS*COLS*CODE_W-1:0] codes
);

    localparam int NCELL = ROWS * COLS;

    function automatic logic all_thermo(input logic [NCELL*CODE_W-1:0] v);
        logic [CODE_W-1:0] c;
        logic [CODE_W-1:0] cp;
        for (int i = 0; i < NCELL; i++) begin
            c  = v[i*CODE_W +: CODE_W];
            cp = c + 1'b1;
            if ((c & cp) != '0) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic bg_clear(input logic [NCELL*CODE_W-1:0] v,
                                      input logic [NCELL-1:0] m);
        for (int i = 0; i < NCELL; i++) begin
            if (!m[i] && v[i*CODE_W +: CODE_W] != '0) return 1'b0;
        end
        return 1'b1;
    endfunction

    // R5: without start, no code loses a 1 bit
    a_r5_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ((codes & $past(codes)) == $past(codes)));

    // R7: start clears codes and done
    a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (codes == '0 && !done));

    // R6: completion holds with frozen codes until the next start
    a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(codes)));

    // R6: never complete while updating
    a_r6_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !done);

    // R9: every code is a thermometer word
    a_r9_thermo: assert property (@(posedge clk) disable iff (!rst_n)
        all_thermo(codes));

    // R2: background cells stay at zero
    a_r2_bg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bg_clear(codes, mask));

endmodule

bind dt_grid dt_grid_chk #(
    .ROWS   (ROWS),
    .COLS   (COLS),
    .CODE_W (CODE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .running (running),
    .mask    (grid_q.mask),
    .codes   (dist_codes)
);

// File: tb/sim_dt_grid.sv
`timescale 1ns/1ps
module sim_dt_grid;

    localparam int R = 6;
    localparam int C = 6;
    localparam int W = 8;
    localparam int N = R * C;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [N-1:0]     obj_map = '0;
    logic [N*W-1:0]   dist_codes;
    logic             done;

    int checks = 0;
    int errors = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #2.5 clk = ~clk;

    dt_grid #(.ROWS(R), .COLS(C), .CODE_W(W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .obj_map    (obj_map),
        .dist_codes (dist_codes),
        .done       (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] thermo(input int d);
        logic [8:0] t;
        t = (9'd1 << d) - 9'd1;
        return t[7:0];
    endfunction

    function automatic int exp_dist(input logic [N-1:0] m, input int idx);
        int best;
        int dd;
        if (!m[idx]) return 0;
        best = 8;
        for (int j = 0; j < N; j++) begin
            if (!m[j]) begin
                dd = ((idx / C > j / C) ? idx / C - j / C : j / C - idx / C)
                   + ((idx % C > j % C) ? idx % C - j % C : j % C - idx % C);
                if (dd < best) best = dd;
            end
        end
        return best;
    endfunction

    function automatic logic [63:0] next_rand();
        rng ^= rng << 13;
        rng ^= rng >> 7;
        rng ^= rng << 17;
        return rng;
    endfunction

    // Run one map; scramble is XORed onto obj_map after the start edge (R10)
    task automatic run_map(input logic [N-1:0] m, input logic [N-1:0] scramble,
                           input string tag);
        int d [N];
        int dmax;
        int bad;
        logic [7:0] got;
        logic [7:0] want;
        dmax = 0;
        for (int i = 0; i < N; i++) begin
            d[i] = exp_dist(m, i);
            if (d[i] > dmax) dmax = d[i];
        end
        @(negedge clk);
        obj_map = m;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        obj_map = m ^ scramble;
        // R7: start edge clears codes and done
        check(dist_codes == '0 && !done, "R7", {tag, " clear on start"},
              {63'd0, done}, 64'd0);
        for (int k = 1; k <= dmax + 1; k++) begin
            @(negedge clk);
            bad = -1;
            got = '0;
            want = '0;
            for (int i = 0; i < N; i++) begin
                if (bad < 0 && dist_codes[i*W +: W] != thermo((k < d[i]) ? k : d[i])) begin
                    bad  = i;
                    got  = dist_codes[i*W +: W];
                    want = thermo((k < d[i]) ? k : d[i]);
                end
            end
            // R5: per-cycle trajectory min(k, d)
            check(bad < 0, "R5", {tag, " trajectory"}, {56'd0, got}, {56'd0, want});
            // R6: done rises exactly at D+1
            check(done == (k == dmax + 1), "R6", {tag, " done timing"},
                  {63'd0, done}, {63'd0, (k == dmax + 1)});
        end
        bad = -1;
        for (int i = 0; i < N; i++)
            if (bad < 0 && !m[i] && dist_codes[i*W +: W] != 8'h00) bad = i;
        check(bad < 0, "R2", {tag, " background zero"}, 64'(bad), 64'hFFFF_FFFF_FFFF_FFFF);
        bad = -1;
        for (int i = 0; i < N; i++)
            if (bad < 0 && m[i] && dist_codes[i*W +: W] != thermo(d[i])) bad = i;
        // R3 / R1: final object codes
        check(bad < 0, (scramble != '0) ? "R10" : "R3", {tag, " final distances"},
              64'(bad), 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    initial begin
        logic [N-1:0] m;
        logic [N*W-1:0] snap;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(dist_codes == '0 && !done, "R8", "reset state", {63'd0, done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dist_codes == '0 && !done, "R8", "after release", {63'd0, done}, 64'd0);

        run_map('0, '0, "all background");
        // R4: no background anywhere saturates every cell
        run_map('1, '0, "all object");
        check(dist_codes == {N*W{1'b1}}, "R4", "saturated grid", dist_codes[63:0], 64'hFFFF_FFFF_FFFF_FFFF);
        // R6: result holds while idle
        snap = dist_codes;
        repeat (4) @(negedge clk);
        check(done && dist_codes == snap, "R6", "idle hold", {63'd0, done}, 64'd1);

        // Every single-background placement (R1 index mapping, R3)
        for (int p = 0; p < N; p++) begin
            m = '1;
            m[p] = 1'b0;
            run_map(m, '0, "single bg");
        end

        // Random maps, object-heavy
        for (int t = 0; t < 300; t++) begin
            m = N'(next_rand() | next_rand());
            if (t % 3 == 0) m = m | N'(next_rand());
            run_map(m, '0, "random");
        end

        // R10: map altered during the run has no effect
        for (int t = 0; t < 20; t++) begin
            m = N'(next_rand() | next_rand());
            run_map(m, N'(next_rand()), "scrambled");
        end

        // R7: start in the middle of a run restarts from scratch
        @(negedge clk);
        obj_map = '1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        m = '1;
        m[0] = 1'b0;
        run_map(m, '0, "restart");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule